// File: doc/BRIEF.md
# Coincident-Decoded RAM Array

A 1024-word by 4-bit random access memory whose storage is laid out as a square grid of 32 rows by 32 columns. The word address is not decoded by one wide 10-to-1024 decoder. Two small 5-to-32 one-hot decoders run side by side instead. The row decoder takes the upper five address bits and the column decoder takes the lower five. A storage word is selected only where its row line and its column line are both active.

Each clock cycle the block takes at most one access, set up by a chip enable and a read/not-write control. The block has no handshake and no back-pressure: any cycle with the chip enable high is an access and is completed at that clock edge. A write updates the single coincident word at the rising edge. The read result is the OR of all cell contents, each gated by its cell select. That result is captured into an output register, so it appears one cycle after the read. In every cycle that is not a read, the output register loads zero.

Top module: `coinc_ram`

## Requirements
- R1: Each of the 1024 addresses holds its own 4-bit word. A value written to one address reads back unchanged after writes to every other address.
- R2: The row index is `addr[9:5]` and the column index is `addr[4:0]`. While `cs` is high, each decoder drives exactly one of its 32 lines, and that line is the one named by its index field.
- R3: While `cs` is low, both decoders drive all zeros and no word is changed. `rdata` is zero after that cycle.
- R4: `rd_nwr` = 1 selects a read and `rd_nwr` = 0 selects a write. A write with `cs` high changes only the word at the row/column crossing, at the rising clock edge.
- R5: A read with `cs` high presents the addressed word on `rdata` after the next rising edge. `rdata` is zero after any write cycle or idle cycle.
- R6: Address 0110000010 selects row 12 and column 2. Writing 1011 there leaves the words at row 12 columns 1 and 3, and at rows 11 and 13 column 2, unchanged.
- R7: Address 0000110100 selects row 1 and column 20, and reads back the word last written there.
- R8: While `rst_n` is low, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cs | input | 1 | Chip enable; high makes this cycle an access |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 10 | Word address: row in bits 9:5, column in bits 4:0 |
| wdata | input | 4 | Word to store on a write |
| rdata | output | 4 | Registered read word; zero when the last cycle was not a read |

## Verification
Both a write and a read take effect at the single rising edge that follows the driven inputs. The read word is therefore due on `rdata` exactly one edge later. The bench drives inputs on the falling edge and samples `rdata` on the next falling edge, so each sample sees the register loaded by that access alone. This includes the zero left by write and idle cycles. A bound checker watches the decoder lines in the same cycle as the address, and it checks a read-after-write pair one edge after the read.

// File: rtl/coinc_ram_pkg.sv
package coinc_ram_pkg;
  typedef enum logic {
    ACC_WRITE = 1'b0,
    ACC_READ  = 1'b1
  } acc_e;
endpackage

// File: rtl/coinc_ram_decoder.sv
module coinc_ram_decoder #(
  parameter int SEL_BITS = 5,
  localparam int LINES   = 1 << SEL_BITS
) (
  input  logic                en,
  input  logic [SEL_BITS-1:0] idx,
  output logic [LINES-1:0]    lines
);
  always_comb begin
    lines = '0;
    if (en) lines[idx] = 1'b1;
  end
endmodule

// File: rtl/coinc_ram_grid.sv
module coinc_ram_grid #(
  parameter int ROWS   = 32,
  parameter int COLS   = 32,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [COLS-1:0]   col_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rword
);
  localparam int CELLS = ROWS * COLS;

  logic [WORD_W-1:0] gated [CELLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic              hit;
      logic [WORD_W-1:0] word_q;
      assign hit = row_sel[r] & col_sel[c];
      always_ff @(posedge clk) begin
        if (hit && wr_en) word_q <= wdata;
      end
      assign gated[r*COLS + c] = hit ? word_q : '0;
    end
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < CELLS; i++) rword = rword | gated[i];
  end
endmodule

// File: rtl/coinc_ram.sv
module coinc_ram #(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 5,
  parameter int WORD_W   = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  import coinc_ram_pkg::*;

  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic [WORD_W-1:0] rword;
  logic              is_read;
  logic              is_write;

  assign is_read  = cs && (rd_nwr == ACC_READ);
  assign is_write = cs && (rd_nwr == ACC_WRITE);

  coinc_ram_decoder #(.SEL_BITS(ROW_BITS)) u_row_dec (
    .en(cs), .idx(addr[ADDR_W-1:COL_BITS]), .lines(row_sel)
  );

  coinc_ram_decoder #(.SEL_BITS(COL_BITS)) u_col_dec (
    .en(cs), .idx(addr[COL_BITS-1:0]), .lines(col_sel)
  );

  coinc_ram_grid #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_grid (
    .clk(clk), .wr_en(is_write), .row_sel(row_sel), .col_sel(col_sel),
    .wdata(wdata), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (is_read) rdata <= rword;
    else              rdata <= '0;
  end
endmodule

// File: rtl/coinc_ram_chk.sv
module coinc_ram_chk #(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 5,
  parameter int WORD_W   = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd_nwr,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] rdata,
  input logic [ROWS-1:0]   row_sel,
  input logic [COLS-1:0]   col_sel
);
  AST_ROW_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> ($countones(row_sel) == 1 && row_sel[addr[ADDR_W-1:COL_BITS]])); // R2
  AST_COL_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> ($countones(col_sel) == 1 && col_sel[addr[COL_BITS-1:0]])); // R2
  AST_IDLE_NO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (row_sel == '0 && col_sel == '0)); // R3
  AST_NONREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd_nwr) |=> rdata == '0); // R5
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_nwr && $past(cs) && !$past(rd_nwr) && addr == $past(addr))
      |=> rdata == $past(wdata, 2)); // R4
  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (rdata == '0); // R8
  end
endmodule

bind coinc_ram coinc_ram_chk #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd_nwr(rd_nwr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .row_sel(row_sel), .col_sel(col_sel)
);

// File: tb/coinc_ram_bench.sv
`timescale 1ns/1ps
module coinc_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       rd_nwr = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [3:0] model [int];

  always #5 clk = ~clk;

  coinc_ram u_coinc_ram (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_nwr(rd_nwr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [3:0] pat(int a, int salt);
    return 4'((a * 5 + (a >> 5) * 3 + salt) & 15);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; the result is sampled at the next falling edge.
  task automatic access(logic c, logic r, int a, logic [3:0] d, output logic [3:0] q);
    @(negedge clk);
    cs = c; rd_nwr = r; addr = 10'(a); wdata = d;
    @(negedge clk);
    q = rdata;
    cs = 1'b0;
    if (c && !r) model[a] = d;
  endtask

  task automatic wr(int a, logic [3:0] d, string req);
    logic [3:0] q;
    access(1'b1, 1'b0, a, d, q);
    chk(req, q, 4'h0);
  endtask

  task automatic rd(int a, string req);
    logic [3:0] q;
    access(1'b1, 1'b1, a, 4'h0, q);
    chk(req, q, model[a]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] q;
    repeat (3) @(negedge clk);
    chk("R8 reset", rdata, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset", rdata, 4'h0);

    // R1 R4: fill every address upward, read all back
    for (int a = 0; a < 1024; a++) wr(a, pat(a, 0), "R5 write cycle");
    for (int a = 0; a < 1024; a++) rd(a, "R1 sweep up");
    // second pattern, filled downward
    for (int a = 1023; a >= 0; a--) wr(a, pat(a, 9), "R5 write cycle");
    for (int a = 0; a < 1024; a++) rd(a, "R1 sweep down");

    // R3: a write attempt with cs low changes nothing and leaves rdata zero
    access(1'b0, 1'b0, 5, ~model[5], q);
    chk("R3 idle rdata", q, 4'h0);
    rd(5, "R3 no write when idle");
    access(1'b0, 1'b1, 5, 4'h0, q);
    chk("R3 idle read", q, 4'h0);

    // R6: row 12 column 2 and its neighbours
    wr(10'b0110000010, 4'b1011, "R6 write");
    rd(10'b0110000010, "R6 target");
    chk("R6 target value", model[386], 4'b1011);
    rd(385, "R6 row12 col1");
    rd(387, "R6 row12 col3");
    rd(354, "R6 row11 col2");
    rd(418, "R6 row13 col2");

    // R7: row 1 column 20
    wr(10'b0000110100, 4'b0110, "R7 write");
    rd(52, "R7 target");
    rd(20, "R7 row0 col20");
    rd(53, "R7 row1 col21");

    // R5: read-to-read back to back, then write, then idle
    rd(1023, "R5 back to back 1");
    rd(0, "R5 back to back 2");
    wr(0, 4'hF, "R5 zero after write");
    access(1'b0, 1'b1, 0, 4'h0, q);
    chk("R5 zero after idle", q, 4'h0);
    rd(0, "R4 write took effect");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule